// File: doc/BRIEF.md
# Sleep-State Power-Saving Delay Controller

This block produces two active-low control outputs that let a platform cut standby power while it sleeps. The first output, `pwr_sus_n`, is a combinational copy of the suspend-sleep input, so it asserts and releases with that input. The second output, `pwr_deep_n`, asserts only after the platform has held one deep sleep state long enough. That state is either S3 (memory kept alive) or S5 (memory off).

The delay is counted in 1 ms ticks taken from an external timebase strobe. A held S3 needs 1024 ticks and a held S5 needs 6400 ticks. Both limits are parameters. Any move to a different sleep state starts the count again from zero. A return to S0, the full-power state, releases the deep output and clears the count.

A five-state machine controls the deep output. `ST_AWAKE` means the platform is in S0. `ST_WAIT_S3` and `ST_WAIT_S5` count ticks toward the limit for their state. `ST_SAVE_S3` and `ST_SAVE_S5` hold `pwr_deep_n` low. The named transitions are:
- ENTER: `ST_AWAKE` to a wait state, when S3 or S5 is requested.
- EXPIRE: a wait state to its save state, on the tick that reaches the limit.
- SWITCH: any S3 state to `ST_WAIT_S5`, or any S5 state to `ST_WAIT_S3`.
- WAKE: any state to `ST_AWAKE`, when S0 is requested.

Top module: `sleep_saving_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with S0 requested, `pwr_deep_n` is 1 and the tick count is zero.
- R2: `pwr_sus_n` equals `sus_slp_n` at all times, with no clock delay.
- R3: The `sleep_state` encoding is 2'b00 = S0, 2'b01 = S3, 2'b10 = S5. The code 2'b11 is treated as S0. While S0 is requested, `pwr_deep_n` stays 1 no matter how many ticks arrive.
- R4: With S3 held and `tick_1ms` high on every cycle, the first edge enters `ST_WAIT_S3`. `pwr_deep_n` falls on the edge that samples the 1024th tick after that entry, which is edge 1025 counted from the request.
- R5: With S5 held, `pwr_deep_n` falls on the edge that samples the 6400th tick after entering `ST_WAIT_S5`.
- R6: Only edges with `tick_1ms` high advance the count. Any number of cycles without a tick leaves `pwr_deep_n` high.
- R7: A direct change between S3 and S5 restarts the count from zero. The new state's full delay then applies, whether the change happens mid-count or while saving.
- R8: A request for S0 sets `pwr_deep_n` to 1 on the next edge and clears the count, so a later S3 or S5 needs its full delay again.
- R9: If a state change and the tick that would reach the limit fall on the same edge, the state change wins. The output stays 1 and the count restarts.
- R10: Once `pwr_deep_n` is 0, it stays 0 while the same deep state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_state | input | 2 | Decoded sleep state (00 S0, 01 S3, 10 S5, 11 as S0) |
| sus_slp_n | input | 1 | Suspend-sleep input, active low |
| tick_1ms | input | 1 | One-cycle 1 ms timebase strobe |
| pwr_sus_n | output | 1 | Suspend power-saving control, active low, copy of `sus_slp_n` |
| pwr_deep_n | output | 1 | Deep power-saving control, active low, asserts after the state delay |

## Verification
The expiry of the delay and a change of sleep state can land on the same clock edge. That edge could then either enter a save state or restart the count. The bench brings the S3 count to 1023 and then presents S5 together with a tick on the edge that would have finished the S3 delay. It then expects `pwr_deep_n` to stay high for the next 6399 ticks and to fall only on the 6400th. A similar case lets S0 meet the terminal tick and expects the output to stay released.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        REQ_S0 = 2'b00,
        REQ_S3 = 2'b01,
        REQ_S5 = 2'b10,
        REQ_RSV = 2'b11
    } sleep_req_e;

    typedef enum logic [2:0] {
        ST_AWAKE   = 3'd0,
        ST_WAIT_S3 = 3'd1,
        ST_WAIT_S5 = 3'd2,
        ST_SAVE_S3 = 3'd3,
        ST_SAVE_S5 = 3'd4
    } ssc_state_e;

endpackage

// File: rtl/ssc_tick_counter.sv
module ssc_tick_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ssc_fsm.sv
module ssc_fsm
    import ssc_pkg::*;
#(
    parameter int S3_TICKS = 1024,
    parameter int S5_TICKS = 6400,
    parameter int CNT_W    = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sleep_state,
    input  logic             tick_1ms,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             pwr_deep_n
);

    localparam logic [CNT_W-1:0] LAST_S3 = CNT_W'(S3_TICKS - 1);
    localparam logic [CNT_W-1:0] LAST_S5 = CNT_W'(S5_TICKS - 1);

    ssc_state_e st, st_nx;
    sleep_req_e req;
    logic       inc_nx;

    assign req = sleep_req_e'(sleep_state);

    // next-state and counter control
    always_comb begin
        st_nx  = st;
        inc_nx = 1'b0;
        unique case (st)
            ST_AWAKE: begin
                if (req == REQ_S3)      st_nx = ST_WAIT_S3;
                else if (req == REQ_S5) st_nx = ST_WAIT_S5;
            end
            ST_WAIT_S3: begin
                if (req == REQ_S5)      st_nx = ST_WAIT_S5;
                else if (req != REQ_S3) st_nx = ST_AWAKE;
                else if (tick_1ms) begin
                    if (cnt == LAST_S3) st_nx = ST_SAVE_S3;
                    else                inc_nx = 1'b1;
                end
            end
            ST_WAIT_S5: begin
                if (req == REQ_S3)      st_nx = ST_WAIT_S3;
                else if (req != REQ_S5) st_nx = ST_AWAKE;
                else if (tick_1ms) begin
                    if (cnt == LAST_S5) st_nx = ST_SAVE_S5;
                    else                inc_nx = 1'b1;
                end
            end
            ST_SAVE_S3: begin
                if (req == REQ_S5)      st_nx = ST_WAIT_S5;
                else if (req != REQ_S3) st_nx = ST_AWAKE;
            end
            ST_SAVE_S5: begin
                if (req == REQ_S3)      st_nx = ST_WAIT_S3;
                else if (req != REQ_S5) st_nx = ST_AWAKE;
            end
            default: st_nx = ST_AWAKE;
        endcase
    end

    assign cnt_clr = (st_nx != st);
    assign cnt_inc = inc_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_AWAKE;
        else        st <= st_nx;
    end

    // outputs
    always_comb begin
        pwr_deep_n = !((st == ST_SAVE_S3) || (st == ST_SAVE_S5));
    end

    AST_S0_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_state == 2'b00 || sleep_state == 2'b11) |=> pwr_deep_n); // R8
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(S5_TICKS)); // R5
    AST_SAVE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_deep_n) |-> $past(tick_1ms)); // R6
    AST_NEW_STATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st != $past(st)) |-> (cnt == '0)); // R7
    AST_SAVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_deep_n && $stable(sleep_state) && sleep_state != 2'b00 && sleep_state != 2'b11)
        |=> !pwr_deep_n); // R10

endmodule

// File: rtl/sleep_saving_ctrl.sv
module sleep_saving_ctrl #(
    parameter int S3_TICKS = 1024,
    parameter int S5_TICKS = 6400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sleep_state,
    input  logic       sus_slp_n,
    input  logic       tick_1ms,
    output logic       pwr_sus_n,
    output logic       pwr_deep_n
);

    localparam int MAX_TICKS = (S3_TICKS > S5_TICKS) ? S3_TICKS : S5_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             cnt_inc;

    assign pwr_sus_n = sus_slp_n;

    ssc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    ssc_fsm #(
        .S3_TICKS (S3_TICKS),
        .S5_TICKS (S5_TICKS),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_state (sleep_state),
        .tick_1ms    (tick_1ms),
        .cnt         (cnt),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc),
        .pwr_deep_n  (pwr_deep_n)
    );

    AST_RESET_RELEASED: assert property (@(posedge clk) $rose(rst_n) |-> pwr_deep_n); // R1

endmodule

// File: tb/sleep_saving_ctrl_bench.sv
module sleep_saving_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // {state[20:19], tick[18], sus[17], edges[16:1], exp_deep_n[0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {2'b00, 1'b1, 1'b1, 16'd5,    1'b1},  // R3 S0 with ticks
        {2'b01, 1'b1, 1'b0, 16'd1024, 1'b1},  // R4 entry + 1023 ticks
        {2'b01, 1'b1, 1'b0, 16'd1,    1'b0},  // R4 1024th tick
        {2'b01, 1'b1, 1'b1, 16'd50,   1'b0},  // R10 held
        {2'b00, 1'b1, 1'b1, 16'd1,    1'b1},  // R8 wake
        {2'b10, 1'b0, 1'b0, 16'd300,  1'b1},  // R6 no ticks
        {2'b10, 1'b1, 1'b0, 16'd6399, 1'b1},  // R5 6399 ticks
        {2'b10, 1'b1, 1'b0, 16'd1,    1'b0},  // R5 6400th tick
        {2'b01, 1'b1, 1'b1, 16'd1024, 1'b1},  // R7 switch from saving
        {2'b01, 1'b1, 1'b1, 16'd1,    1'b0},  // R7 S3 delay done
        {2'b11, 1'b1, 1'b0, 16'd1,    1'b1},  // R3 reserved code as S0
        {2'b11, 1'b1, 1'b1, 16'd2000, 1'b1}   // R3 reserved code held
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sleep_state = 2'b00;
    logic       sus_slp_n = 1'b1;
    logic       tick_1ms = 1'b0;
    logic       pwr_sus_n;
    logic       pwr_deep_n;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_saving_ctrl u_sleep_saving_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_state (sleep_state),
        .sus_slp_n   (sus_slp_n),
        .tick_1ms    (tick_1ms),
        .pwr_sus_n   (pwr_sus_n),
        .pwr_deep_n  (pwr_deep_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive at a negedge, then let n rising edges pass
    task automatic run(input logic [1:0] st, input logic tk, input logic sus, input int n);
        sleep_state = st;
        tick_1ms    = tk;
        sus_slp_n   = sus;
        #1;
        check("R2", pwr_sus_n, sus);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", pwr_deep_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", pwr_deep_n, 1'b1);

        for (int v = 0; v < NVEC; v++) begin
            run(VEC[v][20:19], VEC[v][18], VEC[v][17], int'(VEC[v][16:1]));
            check($sformatf("vector %0d", v), pwr_deep_n, VEC[v][0]);
        end

        // R2: combinational follow, mid cycle
        sus_slp_n = 1'b0; #1; check("R2", pwr_sus_n, 1'b0);
        sus_slp_n = 1'b1; #1; check("R2", pwr_sus_n, 1'b1);
        @(negedge clk);

        // R9: S3 terminal tick meets a switch to S5
        run(2'b00, 1'b0, 1'b1, 2);
        run(2'b01, 1'b1, 1'b1, 1024);
        check("R9 before terminal", pwr_deep_n, 1'b1);
        run(2'b10, 1'b1, 1'b1, 1);
        check("R9 switch wins", pwr_deep_n, 1'b1);
        run(2'b10, 1'b1, 1'b1, 6399);
        check("R9 S5 restarted 6399", pwr_deep_n, 1'b1);
        run(2'b10, 1'b1, 1'b1, 1);
        check("R9 S5 restarted 6400", pwr_deep_n, 1'b0);

        // R9: terminal tick meets a wake to S0
        run(2'b00, 1'b0, 1'b1, 2);
        run(2'b01, 1'b1, 1'b1, 1024);
        run(2'b00, 1'b1, 1'b1, 1);
        check("R9 wake wins", pwr_deep_n, 1'b1);

        // R8: wake clears the count
        run(2'b01, 1'b1, 1'b1, 1001);
        run(2'b00, 1'b0, 1'b1, 1);
        run(2'b01, 1'b1, 1'b1, 1024);
        check("R8 count cleared", pwr_deep_n, 1'b1);
        run(2'b01, 1'b1, 1'b1, 1);
        check("R8 full delay", pwr_deep_n, 1'b0);

        // R7: mid-count switch S3 -> S5 needs full S5 delay
        run(2'b00, 1'b0, 1'b1, 1);
        run(2'b01, 1'b1, 1'b1, 501);
        run(2'b10, 1'b1, 1'b1, 6400);
        check("R7 mid switch 6399", pwr_deep_n, 1'b1);
        run(2'b10, 1'b1, 1'b1, 1);
        check("R7 mid switch 6400", pwr_deep_n, 1'b0);

        // R6: sparse ticks, one in three cycles
        run(2'b00, 1'b0, 1'b1, 1);
        run(2'b01, 1'b0, 1'b1, 1);
        for (int k = 0; k < 1023; k++) begin
            run(2'b01, 1'b1, 1'b1, 1);
            run(2'b01, 1'b0, 1'b1, 2);
        end
        check("R6 sparse 1023", pwr_deep_n, 1'b1);
        run(2'b01, 1'b1, 1'b1, 1);
        check("R6 sparse 1024", pwr_deep_n, 1'b0);

        // R1: reset while saving
        rst_n = 1'b0;
        #1;
        check("R1 async reset", pwr_deep_n, 1'b1);
        run(2'b00, 1'b0, 1'b1, 2);
        rst_n = 1'b1;
        run(2'b00, 1'b0, 1'b1, 2);
        check("R1 after release", pwr_deep_n, 1'b1);

        finish_run();
    end

endmodule